// File: doc/BRIEF.md
# Floating-Point Sign-Injection, Compare and Min-Max Unit

This block carries out the non-arithmetic floating-point operations of a scalar floating-point datapath. It works on single- or double-precision operands, chosen per request by a format code. There are three operation families:

- **Sign injection** builds a value from the magnitude of operand A and a sign derived from operand B.
- **Compare** tests two values and returns a one-bit integer.
- **Min-max** returns the smaller or the larger operand.

The variant inside a family is chosen by a 3-bit sub-operation field, which is the same field the arithmetic operations use for the rounding mode.

Each accepted request produces a registered result, a 5-bit exception flag vector and a valid strobe one clock later. Every NaN that the unit creates is written in canonical quiet form. NaNs that sign injection merely passes through keep their payload. Single-precision operands sit in bits [31:0] of the 64-bit operand ports, and single-precision results are zero-extended.

Top module: `fp_misc_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` and `flags` are updated only when `in_valid` is high and otherwise hold. Reset clears `result`, `flags` and `out_valid` to 0.
- R2: `fmt` 2'b01 selects double precision (1/11/52 bits), and any other value selects single precision (1/8/23 bits). In single precision only bits [31:0] of each operand are used, and `result[63:32]` is 0.
- R3: With `op_sel` 2'b00 (sign injection), the result is A with its sign replaced. For `sub_op` 3'b000 the new sign is B's sign, for 3'b001 it is the inverse of B's sign, and for 3'b010 it is A's sign XOR B's sign.
- R4: Sign injection never sets a flag, and it keeps the exponent and mantissa of A unchanged, NaN payloads included.
- R5: With `op_sel` 2'b01 (compare), the result is 1 or 0 in bit 0 with all other bits 0. `sub_op` 3'b000 tests equal, 3'b001 tests A<B and 3'b010 tests A<=B. +0 and -0 compare equal.
- R6: A compare with any NaN operand returns 0. Less-than and less-or-equal set invalid on any NaN. Equal sets invalid only on a signaling NaN, which is a NaN whose mantissa MSB is 0.
- R7: With `op_sel` 2'b10 (min-max), `sub_op` 3'b000 returns the smaller operand and 3'b001 returns the larger one, with -0 ordered below +0.
- R8: When exactly one min-max operand is NaN, the other operand is returned. When both are NaN, the canonical NaN is returned: 0x7FC00000 in single precision and 0x7FF8000000000000 in double precision. A signaling NaN operand sets invalid.
- R9: The flag vector uses bit0 inexact, bit1 underflow, bit2 overflow, bit3 divide-by-zero and bit4 invalid. This unit only ever sets bit4.
- R10: `op_sel` 2'b11 and any sub-operation code not listed above give result 0 and flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 2 | Operation family: 00 sign injection, 01 compare, 10 min-max |
| sub_op | input | 3 | Variant within the family |
| fmt | input | 2 | Format: 01 double, otherwise single |
| opnd_a | input | 64 | Operand A |
| opnd_b | input | 64 | Operand B |
| result | output | 64 | Registered result |
| flags | output | 5 | Registered exception flags |
| out_valid | output | 1 | Result strobe |

## Verification
On every cycle, the assertions check the following:
- the one-cycle valid timing;
- that no flag other than invalid is ever raised;
- that compare results are confined to bit 0;
- that single-precision results are zero-extended;
- that sign injection raises no flag and keeps A's magnitude;
- that min-max returns one of its operands or the canonical NaN.

Only the bench scenarios can show whether the value chosen is the correct one. That covers the signed ordering including the two zeros, which operand wins around NaNs, and whether invalid follows the quiet/signaling distinction for each compare variant.

// File: rtl/fp_misc_unit.sv
module fp_misc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [1:0]  op_sel,
  input  logic [2:0]  sub_op,
  input  logic [1:0]  fmt,
  input  logic [63:0] opnd_a,
  input  logic [63:0] opnd_b,
  output logic [63:0] result,
  output logic [4:0]  flags,
  output logic        out_valid
);
  localparam logic [1:0] OP_SGNJ = 2'b00;
  localparam logic [1:0] OP_CMP  = 2'b01;
  localparam logic [1:0] OP_MM   = 2'b10;
  localparam logic [63:0] CANON_D = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] CANON_S = 64'h0000_0000_7FC0_0000;

  logic dbl;
  assign dbl = (fmt == 2'b01);

  logic        a_sign, b_sign, a_nan, b_nan, a_snan, b_snan;
  logic [62:0] a_mag, b_mag;
  logic [63:0] a_val, b_val, canon;

  assign a_sign = dbl ? opnd_a[63] : opnd_a[31];
  assign b_sign = dbl ? opnd_b[63] : opnd_b[31];
  assign a_mag  = dbl ? opnd_a[62:0] : {32'd0, opnd_a[30:0]};
  assign b_mag  = dbl ? opnd_b[62:0] : {32'd0, opnd_b[30:0]};
  assign a_val  = dbl ? opnd_a : {32'd0, opnd_a[31:0]};
  assign b_val  = dbl ? opnd_b : {32'd0, opnd_b[31:0]};
  assign canon  = dbl ? CANON_D : CANON_S;

  assign a_nan  = dbl ? (&opnd_a[62:52] && |opnd_a[51:0]) : (&opnd_a[30:23] && |opnd_a[22:0]);
  assign b_nan  = dbl ? (&opnd_b[62:52] && |opnd_b[51:0]) : (&opnd_b[30:23] && |opnd_b[22:0]);
  assign a_snan = a_nan && !(dbl ? opnd_a[51] : opnd_a[22]);
  assign b_snan = b_nan && !(dbl ? opnd_b[51] : opnd_b[22]);

  logic any_nan, any_snan, both_zero, mag_lt, mag_eq;
  assign any_nan   = a_nan | b_nan;
  assign any_snan  = a_snan | b_snan;
  assign both_zero = (a_mag == 63'd0) && (b_mag == 63'd0);
  assign mag_lt    = a_mag < b_mag;
  assign mag_eq    = a_mag == b_mag;

  logic a_lt_b, b_lt_a, num_eq, num_lt;
  assign a_lt_b = (a_sign != b_sign) ? a_sign : (a_sign ? !(mag_lt || mag_eq) : mag_lt);
  assign b_lt_a = (a_sign != b_sign) ? b_sign : (b_sign ? mag_lt : !(mag_lt || mag_eq));
  assign num_eq = both_zero || ((a_sign == b_sign) && mag_eq);
  assign num_lt = !both_zero && a_lt_b;

  logic new_sign;
  always_comb begin
    case (sub_op)
      3'b000:  new_sign = b_sign;
      3'b001:  new_sign = !b_sign;
      default: new_sign = a_sign ^ b_sign;
    endcase
  end

  logic [63:0] nxt_res;
  logic        nxt_nv;
  always_comb begin
    nxt_res = 64'd0;
    nxt_nv  = 1'b0;
    case (op_sel)
      OP_SGNJ: if (sub_op <= 3'b010)
        nxt_res = dbl ? {new_sign, opnd_a[62:0]} : {32'd0, new_sign, opnd_a[30:0]};
      OP_CMP: begin
        case (sub_op)
          3'b000: begin nxt_res[0] = !any_nan && num_eq;            nxt_nv = any_snan; end
          3'b001: begin nxt_res[0] = !any_nan && num_lt;            nxt_nv = any_nan;  end
          3'b010: begin nxt_res[0] = !any_nan && (num_lt || num_eq); nxt_nv = any_nan;  end
          default: ;
        endcase
      end
      OP_MM: if (sub_op <= 3'b001) begin
        nxt_nv = any_snan;
        if (a_nan && b_nan)  nxt_res = canon;
        else if (a_nan)      nxt_res = b_val;
        else if (b_nan)      nxt_res = a_val;
        else if (sub_op[0])  nxt_res = a_lt_b ? b_val : a_val;
        else                 nxt_res = b_lt_a ? b_val : a_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= 64'd0;
      flags     <= 5'd0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        flags  <= {nxt_nv, 4'b0000};
      end
    end
  end
endmodule

// File: rtl/fp_misc_unit_chk.sv
module fp_misc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  op_sel,
  input logic [2:0]  sub_op,
  input logic [1:0]  fmt,
  input logic [63:0] opnd_a,
  input logic [63:0] opnd_b,
  input logic [63:0] result,
  input logic [4:0]  flags,
  input logic        out_valid
);
  p_valid_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flags));
  p_single_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt != 2'b01) |=> result[63:32] == 32'd0);
  p_sgnj_mag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && sub_op <= 3'b010 && fmt == 2'b01)
      |=> result[62:0] == $past(opnd_a[62:0]) && flags == 5'd0);
  p_cmp_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01) |=> result[63:1] == 63'd0);
  p_mm_pick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && sub_op <= 3'b001 && fmt == 2'b01)
      |=> (result == $past(opnd_a) || result == $past(opnd_b) ||
           result == 64'h7FF8_0000_0000_0000));
  p_only_nv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3:0] == 4'd0);
  p_undef_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11) |=> result == 64'd0 && flags == 5'd0);
endmodule

bind fp_misc_unit fp_misc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .sub_op(sub_op), .fmt(fmt), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .result(result), .flags(flags), .out_valid(out_valid)
);

// File: tb/fp_misc_unit_test.sv
`timescale 1ns/1ps
module fp_misc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [2:0]  sub_op = '0;
  logic [1:0]  fmt = '0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [63:0] result;
  logic [4:0]  flags;
  logic        out_valid;

  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp_misc_unit uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct { bit nan; bit snan; bit s; logic [62:0] m; logic [63:0] v; } fv_t;

  function automatic fv_t unpack(logic [63:0] x, bit d);
    fv_t f;
    if (d) begin
      f.s = x[63]; f.m = x[62:0]; f.v = x;
      f.nan = (x[62:52] == 11'h7FF) && (x[51:0] != 0);
      f.snan = f.nan && !x[51];
    end else begin
      f.s = x[31]; f.m = {32'd0, x[30:0]}; f.v = {32'd0, x[31:0]};
      f.nan = (x[30:23] == 8'hFF) && (x[22:0] != 0);
      f.snan = f.nan && !x[22];
    end
    return f;
  endfunction

  // signed order; -0 before +0 when zero_split
  function automatic bit less(fv_t x, fv_t y, bit zero_split);
    if (!zero_split && x.m == 0 && y.m == 0) return 0;
    if (x.s && !y.s) return 1;
    if (!x.s && y.s) return 0;
    return x.s ? (x.m > y.m) : (x.m < y.m);
  endfunction

  function automatic logic [68:0] model(logic [1:0] op, logic [2:0] so, logic [1:0] fm,
                                         logic [63:0] a, logic [63:0] b);
    bit d = (fm == 2'b01);
    fv_t x = unpack(a, d), y = unpack(b, d);
    logic [63:0] r = 0; bit nv = 0; bit s;
    logic [63:0] cn = d ? 64'h7FF8000000000000 : 64'h7FC00000;
    bit eq = (x.m == 0 && y.m == 0) || (x.s == y.s && x.m == y.m);
    if (op == 2'b00 && so <= 2) begin
      s = (so == 0) ? y.s : (so == 1) ? !y.s : (x.s ^ y.s);
      r = d ? {s, a[62:0]} : {32'd0, s, a[30:0]};
    end else if (op == 2'b01 && so <= 2) begin
      nv = (so == 0) ? (x.snan || y.snan) : (x.nan || y.nan);
      if (!x.nan && !y.nan)
        r[0] = (so == 0) ? eq : (so == 1) ? less(x, y, 0) : (less(x, y, 0) || eq);
    end else if (op == 2'b10 && so <= 1) begin
      nv = x.snan || y.snan;
      if (x.nan && y.nan) r = cn;
      else if (x.nan) r = y.v;
      else if (y.nan) r = x.v;
      else if (so == 0) r = less(y, x, 1) ? y.v : x.v;
      else r = less(x, y, 1) ? y.v : x.v;
    end
    return {nv, 4'b0000, r};
  endfunction

  function automatic string tag_of(logic [1:0] op, logic [2:0] so);
    if (op == 2'b11) return "R10";
    if (op == 2'b00) return (so <= 2) ? "R3" : "R10";
    if (op == 2'b01) return (so <= 2) ? "R5/R6" : "R10";
    return (so <= 1) ? "R7/R8" : "R10";
  endfunction

  task automatic run(input logic [1:0] op, input logic [2:0] so, input logic [1:0] fm,
                     input logic [63:0] a, input logic [63:0] b, input string req);
    logic [68:0] e;
    op_sel = op; sub_op = so; fmt = fm; opnd_a = a; opnd_b = b; in_valid = 1'b1;
    e = model(op, so, fm, a, b);
    @(negedge clk);
    check({req, " result"}, result, e[63:0]);
    check({req, " flags R9"}, {59'd0, flags}, {59'd0, e[68:64]});
    check("R1 out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] pick(bit d, logic [63:0] other);
    logic [63:0] r = {$urandom, $urandom};
    int k = $urandom_range(0, 7);
    if (d) case (k)
      0: r = {r[63], 63'd0};
      1: r = {r[63], 11'h7FF, 52'd0};
      2: r = {r[63], 11'h7FF, 1'b1, r[50:0]};
      3: r = {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
      4: r = other;
      5: r = {~other[63], other[62:0]};
      default: ;
    endcase
    else case (k)
      0: r[31:0] = {r[31], 31'd0};
      1: r[31:0] = {r[31], 8'hFF, 23'd0};
      2: r[31:0] = {r[31], 8'hFF, 1'b1, r[21:0]};
      3: r[31:0] = {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
      4: r[31:0] = other[31:0];
      5: r[31:0] = {~other[31], other[30:0]};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 64'd0);
    check("R1 reset flags", {59'd0, flags}, 64'd0);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;

    // R3 sign injection, single with junk high bits (R2)
    run(2'b00, 3'b000, 2'b00, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_8000_0000, "R3 R2 copy");
    run(2'b00, 3'b001, 2'b01, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, "R3 negate");
    run(2'b00, 3'b010, 2'b01, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, "R3 xor");
    run(2'b00, 3'b000, 2'b01, 64'h7FF0_0000_0000_0001, 64'h8000_0000_0000_0000, "R4 snan payload");
    // R5 compare, zeros
    run(2'b01, 3'b000, 2'b00, 64'h0000_0000_8000_0000, 64'h0, "R5 -0 eq +0");
    run(2'b01, 3'b001, 2'b01, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, "R5 lt neg");
    run(2'b01, 3'b010, 2'b01, 64'h8000_0000_0000_0000, 64'h0, "R5 le zeros");
    // R6 NaN compares
    run(2'b01, 3'b000, 2'b00, 64'h7FC0_0001, 64'h7FC0_0001, "R6 eq qnan");
    run(2'b01, 3'b000, 2'b00, 64'h7F80_0001, 64'h0, "R6 eq snan");
    run(2'b01, 3'b001, 2'b01, 64'h7FF8_0000_0000_0000, 64'h0, "R6 lt qnan");
    // R7/R8 min-max
    run(2'b10, 3'b000, 2'b00, 64'h0, 64'h8000_0000, "R7 min zeros");
    run(2'b10, 3'b001, 2'b00, 64'h8000_0000, 64'h0, "R7 max zeros");
    run(2'b10, 3'b000, 2'b01, 64'h7FF0_0000_0000_0001, 64'h3FF0_0000_0000_0000, "R8 one snan");
    run(2'b10, 3'b001, 2'b00, 64'h7FC0_0000, 64'hFF80_0001, "R8 both nan");
    run(2'b10, 3'b000, 2'b01, 64'hFFF8_0000_0000_0005, 64'h7FF0_0000_0000_0002, "R8 both nan dbl");
    // R10 undefined codes
    run(2'b11, 3'b000, 2'b01, 64'h7FF0_0000_0000_0001, 64'h1, "R10 op3");
    run(2'b01, 3'b011, 2'b01, 64'h7FF0_0000_0000_0001, 64'h1, "R10 cmp code");
    run(2'b10, 3'b010, 2'b00, 64'h1, 64'h2, "R10 mm code");

    // R1 hold while idle
    run(2'b10, 3'b001, 2'b00, 64'h4000_0000, 64'h3F80_0000, "R7 max");
    in_valid = 1'b0; opnd_a = 64'h7F80_0001; op_sel = 2'b01; sub_op = 3'b001;
    @(negedge clk);
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);
    check("R1 idle hold", result, 64'h4000_0000);
    check("R1 idle flags", {59'd0, flags}, 64'd0);

    for (int i = 0; i < 2000; i++) begin
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [2:0] so = 3'($urandom_range(0, 3));
      logic [1:0] fm = 2'($urandom_range(0, 2));
      logic [63:0] b = pick(fm == 2'b01, 64'd0);
      logic [63:0] a = pick(fm == 2'b01, b);
      run(op, so, fm, a, b, tag_of(op, so));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule